// File: doc/BRIEF.md
# Goldschmidt Iterative Mantissa Divider

This block divides one normalized fixed-point mantissa by another. It takes two operands in the range [1, 2) and returns an approximate quotient in the same fixed-point format. A caller pulses `start` with the dividend and divisor present. The block looks up a reciprocal seed for the divisor and multiplies both operands by that seed. It then runs a fixed number of Goldschmidt refinement steps. After a final correction it raises `done` for one cycle, with the quotient on `quotient`.

Only one multiplier is present, and it is shared in time. The scaling steps and the refinement steps each use it on the denominator first and then on the numerator. Each refinement factor is the bitwise inversion of the current denominator, which equals two minus the denominator less one unit in the last place. Every intermediate product is truncated back to the operand width. The last numerator product is kept at full width. A fixed correction and a half-unit rounding term are added to it, and the result is clamped to the largest code.

The seed table has 2^K entries and is indexed by the K fraction bits that sit just below the divisor's integer bit. Each entry holds the reciprocal of its interval's midpoint, rounded to M-1 fraction bits. These entries are computed when the design is elaborated. The block handles no sign, exponent, special value or rounding mode.

Top module: `gs_divider`

## Requirements
- R1: While reset is high and afterwards until the first accepted start, `busy`, `done` and `quotient` are all zero.
- R2: Operands and the quotient are unsigned with one integer bit (the MSB) and M-1 fraction bits, so one unit in the last place (ulp) is 2^-(M-1). For any dividend and divisor with the MSB set, the quotient is within 6 ulp of the exact ratio.
- R3: When the divisor is exactly 1.0 (only the MSB set), and when dividend equals divisor, the quotient is still within 6 ulp of the exact ratio. For equal operands the exact ratio is 1.0.
- R4: When the divisor is the largest code (all ones, just below 2.0), the quotient is within 6 ulp of the exact ratio.
- R5: The quotient never wraps. A result of 2.0 or more is clamped to all ones, so an all-ones dividend over a divisor of 1.0 returns a code no lower than all ones minus 6.
- R6: A start sampled while `busy` is low is accepted. `busy` is high on the next cycle, and `done` rises exactly 4 + 2*MAX_ITER clock edges after the edge that sampled the start.
- R7: `done` is high for exactly one cycle per accepted start.
- R8: A start sampled while `busy` is high is ignored. This includes the cycle in which `done` is high. The computation in flight finishes with its own operands and gives a single `done`, and no new computation starts.
- R9: `quotient` changes only on the cycle `done` rises. It holds its value until the next accepted computation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; sampled only while idle |
| dividend | input | M | Numerator mantissa, one integer bit |
| divisor | input | M | Denominator mantissa, one integer bit |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | M | Result, held until the next completion |

## Verification
The bench builds the block with M=16, K=4, MAX_ITER=2 and CORR=1.

With this 16-entry table the seed is good to about five bits. Two refinement steps therefore push the convergence error below one ulp, so only the truncation and inversion errors remain for the 6 ulp window to absorb.

At 16 bits an exact reference is one 64-bit integer division, so hundreds of random operand pairs cost little. The small width also makes it possible to hit the divisor extremes, equal operands and the clamp at all ones exactly.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SCALE_D,
        ST_SCALE_N,
        ST_ITER_D,
        ST_ITER_N,
        ST_FINAL,
        ST_DONE
    } gs_state_e;

    // Reciprocal of the midpoint of seed interval i, with M-1 fraction bits.
    // The midpoint is 1 + (2i+1)/2^(K+1); the value is rounded to nearest.
    function automatic longint seed_value(input int m, input int k, input int i);
        longint den;
        longint num;
        den = (longint'(1) << (k + 1)) + longint'(2 * i + 1);
        num = longint'(1) << (m + k);
        return (2 * num + den) / (2 * den);
    endfunction

endpackage

// File: rtl/gs_seed_rom.sv
`timescale 1ns/1ps
module gs_seed_rom
    import gs_pkg::*;
#(
    parameter int M = 16,
    parameter int K = 4
) (
    input  logic [K-1:0] idx,
    output logic [M-1:0] seed
);
    localparam int ENTRIES = 2 ** K;

    logic [M-1:0] tbl [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam logic [M-1:0] SV = M'(seed_value(M, K, i));
        assign tbl[i] = SV;
    end

    assign seed = tbl[idx];
endmodule

// File: rtl/gs_mul.sv
`timescale 1ns/1ps
module gs_mul #(
    parameter int M = 16
) (
    input  logic [M-1:0]   x,
    input  logic [M-1:0]   y,
    output logic [2*M-1:0] p
);
    assign p = {{M{1'b0}}, x} * {{M{1'b0}}, y};
endmodule

// File: rtl/gs_ctrl.sv
`timescale 1ns/1ps
module gs_ctrl
    import gs_pkg::*;
#(
    parameter int MAX_ITER = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output gs_state_e state,
    output logic      last_iter,
    output logic      busy,
    output logic      done
);
    localparam int IW = $clog2(MAX_ITER + 1);

    logic [IW-1:0] iter;
    gs_state_e     nxt;

    assign last_iter = (iter == IW'(MAX_ITER - 1));
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (start) nxt = ST_LOOKUP;
            ST_LOOKUP:  nxt = ST_SCALE_D;
            ST_SCALE_D: nxt = ST_SCALE_N;
            ST_SCALE_N: nxt = ST_ITER_D;
            ST_ITER_D:  nxt = ST_ITER_N;
            ST_ITER_N:  nxt = last_iter ? ST_FINAL : ST_ITER_D;
            ST_FINAL:   nxt = ST_DONE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_SCALE_N)
                iter <= '0;
            else if (state == ST_ITER_N && !last_iter)
                iter <= iter + 1'b1;
        end
    end
endmodule

// File: rtl/gs_divider.sv
`timescale 1ns/1ps
module gs_divider
    import gs_pkg::*;
#(
    parameter int M        = 16,
    parameter int K        = 4,
    parameter int MAX_ITER = 2,
    parameter int CORR     = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] dividend,
    input  logic [M-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] quotient
);
    localparam int PW = 2 * M;
    localparam logic [PW:0] FIN_ADD = ((PW+1)'(CORR) << (M - 1)) + ((PW+1)'(1) << (M - 2));
    localparam logic [PW:0] TOP_CODE = (PW+1)'({M{1'b1}});

    typedef struct packed {
        logic [M-1:0] a;
        logic [M-1:0] b;
        logic [M-1:0] t;
        logic [M-1:0] d;
        logic [M-1:0] n;
        logic [M-1:0] r;
    } work_t;

    work_t         w;
    logic [PW-1:0] wide;
    gs_state_e     state;
    logic          last_iter;
    logic [M-1:0]  seed;
    logic [M-1:0]  mx;
    logic [M-1:0]  my;
    logic [PW-1:0] prod;

    gs_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .state     (state),
        .last_iter (last_iter),
        .busy      (busy),
        .done      (done)
    );

    gs_seed_rom #(.M(M), .K(K)) u_rom (
        .idx  (w.b[M-2 -: K]),
        .seed (seed)
    );

    gs_mul #(.M(M)) u_mul (
        .x (mx),
        .y (my),
        .p (prod)
    );

    // Drop the low M-1 product bits; clamp if the value reached 2.0.
    function automatic logic [M-1:0] fold(input logic [PW-1:0] p);
        logic [PW:0] s;
        s = {1'b0, p} >> (M - 1);
        if (s > TOP_CODE) return '1;
        return s[M-1:0];
    endfunction

    // Full-width last product plus correction and half-ulp rounding.
    function automatic logic [M-1:0] finish(input logic [PW-1:0] p);
        logic [PW:0] s;
        s = ({1'b0, p} + FIN_ADD) >> (M - 1);
        if (s > TOP_CODE) return '1;
        return s[M-1:0];
    endfunction

    always_comb begin
        mx = '0;
        my = '0;
        case (state)
            ST_SCALE_D: begin mx = w.b; my = w.t;  end
            ST_SCALE_N: begin mx = w.a; my = w.t;  end
            ST_ITER_D:  begin mx = w.d; my = ~w.d; end
            ST_ITER_N:  begin mx = w.n; my = w.r;  end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w        <= '0;
            wide     <= '0;
            quotient <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    w.a <= dividend;
                    w.b <= divisor;
                end
                ST_LOOKUP:  w.t <= seed;
                ST_SCALE_D: w.d <= fold(prod);
                ST_SCALE_N: w.n <= fold(prod);
                ST_ITER_D: begin
                    w.r <= ~w.d;
                    w.d <= fold(prod);
                end
                ST_ITER_N: begin
                    if (last_iter) wide <= prod;
                    else           w.n  <= fold(prod);
                end
                ST_FINAL: quotient <= finish(wide);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gs_divider_chk.sv
`timescale 1ns/1ps
module gs_divider_chk #(
    parameter int M   = 16,
    parameter int LAT = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] quot
);
    localparam int CW = $clog2(LAT + 2) + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start && !busy)
            cnt <= '0;
        else if (busy && cnt != CMAX)
            cnt <= cnt + 1'b1;
    end

    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: result register moves only with the completion pulse
    a_r9_quot_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(quot) |-> done);

    // R6: acceptance from idle makes the block busy
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

    // R6: completion arrives a fixed number of edges after acceptance
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == CW'(LAT)));
endmodule

bind gs_divider gs_divider_chk #(.M(M), .LAT(4 + 2 * MAX_ITER)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .quot  (quotient)
);

// File: tb/sim_gs_divider.sv
`timescale 1ns/1ps
module sim_gs_divider;
    localparam int M        = 16;
    localparam int K        = 4;
    localparam int MAX_ITER = 2;
    localparam int CORR     = 1;
    localparam int LAT      = 4 + 2 * MAX_ITER;
    localparam longint TOL8 = 6 * 256;

    // {dividend, divisor, floor of exact quotient in ulps}
    localparam logic [47:0] VEC [9] = '{
        {16'h8000, 16'h8000, 16'h8000},
        {16'hC000, 16'h8000, 16'hC000},
        {16'h8000, 16'hC000, 16'h5555},
        {16'hC000, 16'hC000, 16'h8000},
        {16'hFFFF, 16'hFFFF, 16'h8000},
        {16'h8000, 16'hFFFF, 16'h4000},
        {16'hA000, 16'hA000, 16'h8000},
        {16'hF000, 16'hA000, 16'hC000},
        {16'h9000, 16'hC000, 16'h6000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [M-1:0] dividend = '0;
    logic [M-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [M-1:0] quotient;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gs_divider #(.M(M), .K(K), .MAX_ITER(MAX_ITER), .CORR(CORR)) u0 (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (busy),
        .done     (done),
        .quotient (quotient)
    );

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Accuracy against an exact reference with 8 extra fraction bits.
    task automatic acc(input string tag, input logic [M-1:0] a, input logic [M-1:0] b,
                       input logic [M-1:0] q);
        longint r8, q8, d;
        r8 = (longint'(a) << (M - 1 + 8)) / longint'(b);
        q8 = longint'(q) << 8;
        d  = q8 - r8;
        if (d < 0) d = -d;
        chk(tag, d <= TOL8, longint'(q), r8 >> 8);
    endtask

    // Pulse start at a falling edge, wait for done; lat counts edges after acceptance.
    task automatic run_div(input logic [M-1:0] a, input logic [M-1:0] b,
                           output logic [M-1:0] q, output int lat);
        int cyc;
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        lat = cyc - 1;
        q   = quotient;
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [M-1:0] q;
        logic [M-1:0] held;
        int lat;
        int pulses;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy == 1'b0, longint'(busy), 0);
        chk("R1 done in reset", done == 1'b0, longint'(done), 0);
        chk("R1 quotient in reset", quotient == '0, longint'(quotient), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 quotient idle after reset", quotient == '0 && !busy && !done,
            longint'(quotient), 0);

        // R2: vector table
        for (int i = 0; i < 9; i++) begin
            logic [M-1:0] va, vb, ve;
            {va, vb, ve} = VEC[i];
            run_div(va, vb, q, lat);
            acc("R2 vector", va, vb, q);
            chk("R2 vector vs table", (longint'(q) - longint'(ve) <= 6) &&
                (longint'(ve) - longint'(q) <= 6), longint'(q), longint'(ve));
            chk("R6 latency", lat == LAT, lat, LAT);
            @(negedge clk);
            chk("R7 done low after one cycle", done == 1'b0, longint'(done), 0);
        end

        // R2: random normalized operands
        for (int i = 0; i < 300; i++) begin
            logic [M-1:0] ra, rb;
            ra = 16'h8000 | M'($urandom());
            rb = 16'h8000 | M'($urandom());
            run_div(ra, rb, q, lat);
            acc("R2 random", ra, rb, q);
        end

        // R3: divisor exactly one, and equal operands
        run_div(16'hB6DB, 16'h8000, q, lat);
        acc("R3 divisor one", 16'hB6DB, 16'h8000, q);
        run_div(16'h8001, 16'h8000, q, lat);
        acc("R3 divisor one small", 16'h8001, 16'h8000, q);
        run_div(16'hD37A, 16'hD37A, q, lat);
        acc("R3 equal operands", 16'hD37A, 16'hD37A, q);
        run_div(16'h8000, 16'h8000, q, lat);
        acc("R3 both one", 16'h8000, 16'h8000, q);

        // R4: divisor just below two
        run_div(16'hFFFE, 16'hFFFF, q, lat);
        acc("R4 divisor max", 16'hFFFE, 16'hFFFF, q);
        run_div(16'hC123, 16'hFFFF, q, lat);
        acc("R4 divisor max mid", 16'hC123, 16'hFFFF, q);

        // R5: result at the top of the range does not wrap
        run_div(16'hFFFF, 16'h8000, q, lat);
        chk("R5 no wrap", q >= 16'hFFF9, longint'(q), 16'hFFFF);
        run_div(16'hFFFF, 16'h8001, q, lat);
        acc("R5 near top", 16'hFFFF, 16'h8001, q);

        // R8: start while busy is ignored
        @(negedge clk);
        dividend = 16'hC000;
        divisor  = 16'h8000;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (2) begin @(negedge clk); lat++; end
        dividend = 16'h8000;
        divisor  = 16'hFFFF;
        start    = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency from first start", (lat - 1) == LAT, lat - 1, LAT);
        acc("R8 first operands kept", 16'hC000, 16'h8000, quotient);
        held = quotient;

        // R8: start during the done cycle is ignored too
        dividend = 16'h9000;
        divisor  = 16'hC000;
        start    = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        pulses = 0;
        for (int i = 0; i < LAT + 6; i++) begin
            if (done) pulses++;
            @(negedge clk);
        end
        chk("R8 no extra done", pulses == 0, pulses, 0);
        chk("R8 not busy after ignored start", busy == 1'b0, longint'(busy), 0);

        // R9: quotient held while idle
        chk("R9 quotient held", quotient == held, longint'(quotient), longint'(held));
        repeat (5) @(negedge clk);
        chk("R9 quotient held longer", quotient == held, longint'(quotient), longint'(held));

        summary();
        $finish;
    end
endmodule